// File: doc/BRIEF.md
# Divider Setting Loader with Parallel and Serial Programming

This block holds the three settings that a clock divider block consumes: a 9-bit feedback divide value (M), a 2-bit output divide code (N) and a 3-bit test-output select code (T). The settings can be written in two ways. Parallel pins carry M and N directly. A 14-bit shift register, filled one bit at a time from a serial data line on the rising edge of a serial clock, carries all three fields.

An active-low mode pin chooses between the two paths. While the pin is low, the settings follow the parallel pins. When the pin rises, the last values are kept. When the pin is high, the serial load strobe controls the outputs. While the strobe is high, the outputs track the shift register, so every serial clock edge reaches the divider. When the strobe falls, the outputs freeze. The most significant stage of the shift register drives a serial output, so a shifted frame can be read back.

All control inputs are asynchronous to the block clock. Each passes through a synchronizer of `SYNC_STAGES` flops. The serial clock is turned into an edge pulse by oversampling it, so it must stay high and low for more than `SYNC_STAGES` block clock periods.

Top module: `cfg_loader`

## Requirements
- R1: After reset the outputs are M = 125, N = 0, T = 0, and the serial output is 0 because the shift register is cleared.
- R2: While `par_load_n` is low, `m_out` and `n_out` follow `m_pins` and `n_pins`, arriving SYNC_STAGES+1 clocks after the pins change.
- R3: While `par_load_n` is high and `ser_load` is low, changes on the parallel pins have no effect on any output setting. A rising edge on `par_load_n` keeps the values last passed through.
- R4: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 and moves every other bit up by one. The frame is sent T2 first, then T1, T0, N1, N0 and M8 to M0, so M0 is the last bit in. In the shift register, bits 13:11 hold T, bits 10:9 hold N and bits 8:0 hold M.
- R5: `ser_out` is bit 13 of the shift register, so a stored frame leaves it MSB first as new bits are shifted in.
- R6: A rising edge of `ser_load` while `par_load_n` is high copies the T, N and M fields of the shift register into `t_out`, `n_out` and `m_out`.
- R7: While `ser_load` stays high with `par_load_n` high, every serial clock edge passes the new shift register contents straight to the outputs.
- R8: After `ser_load` falls, further serial shifts leave the outputs unchanged.
- R9: `t_out` changes only through the serial path. Parallel mode never alters it.
- R10: Serial clock edges while `par_load_n` is low do not shift the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_load_n | input | 1 | Low: parallel pins pass through; high: serial path in control |
| m_pins | input | 9 | Parallel M value |
| n_pins | input | 2 | Parallel N code |
| ser_clk | input | 1 | Serial shift clock (oversampled) |
| ser_data | input | 1 | Serial data line |
| ser_load | input | 1 | Serial load strobe: rise loads, high is transparent, fall holds |
| m_out | output | 9 | Effective M setting |
| n_out | output | 2 | Effective N code |
| t_out | output | 3 | Effective test-select code |
| ser_out | output | 1 | Shift register MSB |

## Verification
A corrupted shift register stays hidden until it is either read back or loaded. The bench therefore checks `ser_out` after single shifts, and loads the register after a run of parallel-mode serial clocks to show that those clocks left it untouched. A fault in the hold/transparent decision appears on `m_out`, `n_out` or `t_out` within SYNC_STAGES+1 clocks of the mode or strobe change that triggers it. The bench moves the parallel pins and the serial data during every hold phase so that such a fault becomes visible.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;
  localparam logic [M_W-1:0] M_DEFAULT = M_W'(125);

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
    cfg_t c;
    c.t = f[FRAME_W-1 -: T_W];
    c.n = f[M_W +: N_W];
    c.m = f[M_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] src;
    if (i == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= src;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_ok,
  input  logic               sclk,
  input  logic               sdata,
  output logic [FRAME_W-1:0] sr,
  output logic [FRAME_W-1:0] sr_next,
  output logic               sout
);
  logic sclk_q;
  logic rise;
  logic shift_en;

  always_comb begin
    rise     = sclk & ~sclk_q;
    shift_en = shift_ok & rise;
    sr_next  = sr;
    if (shift_en) sr_next = {sr[FRAME_W-2:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sr     <= '0;
    end else begin
      sclk_q <= sclk;
      if (shift_en) sr <= sr_next;
    end
  end

  assign sout = sr[FRAME_W-1];
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import cfg_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_n,
  input  logic               ld,
  input  logic [M_W-1:0]     m_pin,
  input  logic [N_W-1:0]     n_pin,
  input  logic [FRAME_W-1:0] frame,
  output cfg_t               cfg
);
  cfg_t cfg_d;
  logic upd;

  always_comb begin
    cfg_d = cfg;
    upd   = 1'b0;
    if (!par_n) begin
      cfg_d.m = m_pin;
      cfg_d.n = n_pin;
      upd     = 1'b1;
    end else if (ld) begin
      cfg_d = frame_to_cfg(frame);
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.t <= '0;
      cfg.n <= '0;
      cfg.m <= M_DEFAULT;
    end else if (upd) begin
      cfg <= cfg_d;
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] m_pins,
  input  logic [N_W-1:0] n_pins,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           ser_out
);
  localparam int CTL_W = 4;
  localparam int PIN_W = M_W + N_W;

  logic             pl_s_n, sclk_s, sd_s, ld_s;
  logic [M_W-1:0]   m_s;
  logic [N_W-1:0]   n_s;
  logic [FRAME_W-1:0] sr, sr_next;
  cfg_t             cfg;

  // par_load_n resets high so the block starts in serial-hold and keeps defaults
  cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_W'(4'b1000))) i_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({par_load_n, ser_clk, ser_data, ser_load}),
    .q({pl_s_n, sclk_s, sd_s, ld_s})
  );

  cfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_pin (
    .clk(clk), .rst_n(rst_n),
    .d({m_pins, n_pins}),
    .q({m_s, n_s})
  );

  cfg_shift i_shift (
    .clk(clk), .rst_n(rst_n), .shift_ok(pl_s_n),
    .sclk(sclk_s), .sdata(sd_s),
    .sr(sr), .sr_next(sr_next), .sout(ser_out)
  );

  cfg_hold i_hold (
    .clk(clk), .rst_n(rst_n), .par_n(pl_s_n), .ld(ld_s),
    .m_pin(m_s), .n_pin(n_s), .frame(sr_next), .cfg(cfg)
  );

  assign m_out = cfg.m;
  assign n_out = cfg.n;
  assign t_out = cfg.t;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pl_s_n,
  input logic               ld_s,
  input logic               sclk_s,
  input logic [M_W-1:0]     m_s,
  input logic [N_W-1:0]     n_s,
  input logic [FRAME_W-1:0] sr,
  input logic [M_W-1:0]     m_out,
  input logic [N_W-1:0]     n_out,
  input logic [T_W-1:0]     t_out,
  input logic               ser_out
);
  p_par_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s_n |=> (m_out == $past(m_s)) && (n_out == $past(n_s)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s_n && !ld_s) |=> $stable(m_out) && $stable(n_out) && $stable(t_out));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s_n && sclk_s && !$past(sclk_s)) |=> (ser_out == $past(sr[FRAME_W-2])));

  p_transparent_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_s_n && ld_s) |=> ({t_out, n_out, m_out} == sr));

  p_t_parallel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s_n |=> $stable(t_out));

  p_no_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_s_n |=> $stable(sr));
endmodule

bind cfg_loader cfg_loader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pl_s_n(pl_s_n), .ld_s(ld_s), .sclk_s(sclk_s),
  .m_s(m_s), .n_s(n_s), .sr(sr), .m_out(m_out), .n_out(n_out),
  .t_out(t_out), .ser_out(ser_out)
);

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_load_n, ser_clk, ser_data, ser_load;
  logic [8:0] m_pins;
  logic [1:0] n_pins;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] t_out;
  logic       ser_out;

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [2:0] t;
    logic       use_sout;
    logic       sout;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic [13:0] sr_m;
  bit         done = 0;

  always #10 clk = ~clk;

  cfg_loader i_cfg_loader (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .m_pins(m_pins),
    .n_pins(n_pins), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_out(n_out), .t_out(t_out), .ser_out(ser_out)
  );

  // Monitor: pop one expected item per cycle and compare
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (m_out !== e.m || n_out !== e.n || t_out !== e.t ||
          (e.use_sout && ser_out !== e.sout)) begin
        n_bad++;
        $display("FAIL %s: got m=%0d n=%0d t=%0d so=%b, expected m=%0d n=%0d t=%0d so=%b",
                 e.tag, m_out, n_out, t_out, ser_out, e.m, e.n, e.t, e.sout);
      end
    end
  end

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_cfg(string tag, logic [8:0] m, logic [1:0] n, logic [2:0] t,
                            logic use_so, logic so);
    exp_t e;
    settle();
    e.m = m; e.n = n; e.t = t; e.use_sout = use_so; e.sout = so; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic expect_frame(string tag, logic [13:0] f);
    expect_cfg(tag, f[8:0], f[10:9], f[13:11], 1'b1, sr_m[13]);
  endtask

  task automatic pulse_bit(logic b);
    ser_data = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    if (par_load_n) sr_m = {sr_m[12:0], b};
  endtask

  task automatic shift_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) pulse_bit(f[i]);
  endtask

  initial begin
    logic [13:0] f1, f2;
    logic [13:0] keep;
    f1 = {3'd5, 2'd1, 9'd341};
    f2 = {3'd2, 2'd2, 9'd160};
    sr_m = '0;
    rst_n = 1'b0; par_load_n = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
    ser_load = 1'b0; m_pins = '0; n_pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_cfg("R1 reset state", 9'd125, 2'd0, 3'd0, 1'b1, 1'b0);

    m_pins = 9'd300; n_pins = 2'd3;
    expect_cfg("R3 pins ignored in serial hold", 9'd125, 2'd0, 3'd0, 1'b0, 1'b0);

    par_load_n = 1'b0; m_pins = 9'd200; n_pins = 2'd2;
    expect_cfg("R2 parallel pass-through", 9'd200, 2'd2, 3'd0, 1'b0, 1'b0);
    m_pins = 9'd131; n_pins = 2'd3;
    expect_cfg("R2 R9 parallel follows second value, T kept", 9'd131, 2'd3, 3'd0, 1'b0, 1'b0);

    par_load_n = 1'b1;
    settle();
    m_pins = 9'd5; n_pins = 2'd0;
    expect_cfg("R3 captured on par_load_n rise", 9'd131, 2'd3, 3'd0, 1'b0, 1'b0);

    shift_frame(f1);
    expect_cfg("R4 R5 shift held, MSB on ser_out", 9'd131, 2'd3, 3'd0, 1'b1, 1'b1);

    ser_load = 1'b1;
    expect_frame("R6 load on strobe rise", f1);

    pulse_bit(1'b0);
    expect_frame("R7 transparent shift 0", sr_m);
    pulse_bit(1'b1);
    expect_frame("R7 transparent shift 1", sr_m);

    ser_load = 1'b0;
    settle();
    keep = sr_m;
    pulse_bit(1'b1);
    expect_cfg("R8 R5 frozen after fall, readback", keep[8:0], keep[10:9], keep[13:11],
               1'b1, sr_m[13]);
    shift_frame(f2);
    expect_cfg("R8 R4 frozen after full frame", keep[8:0], keep[10:9], keep[13:11],
               1'b1, 1'b0);

    par_load_n = 1'b0; m_pins = 9'd150; n_pins = 2'd0;
    settle();
    for (int k = 0; k < 5; k++) pulse_bit(1'b1);
    expect_cfg("R2 R9 parallel after serial, T kept", 9'd150, 2'd0, keep[13:11], 1'b1, 1'b0);

    par_load_n = 1'b1;
    settle();
    ser_load = 1'b1;
    expect_frame("R10 R6 register unchanged by parallel-mode clocks", f2);
    ser_load = 1'b0;
    settle();

    par_load_n = 1'b0; m_pins = 9'd250; n_pins = 2'd1;
    expect_cfg("R9 T survives parallel write", 9'd250, 2'd1, 3'd2, 1'b0, 1'b0);

    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule